// File: doc/BRIEF.md
# Banked CMOS RAM with Range Lock

This block is a host-visible, battery-style configuration RAM reached through index/data register pairs. There are two banks of 128 bytes each. For each bank, the host writes a byte address into the bank's index register and then reads or writes that byte through the bank's data register. Index bit 7 is kept in the register but plays no part in address decoding. The first sixteen bytes of bank 0 are the time, calendar, alarm and control locations. They behave as plain storage, with one exception: bit 0 of location 0x0B is read-only and always reads zero.

A lock register holds four sticky bits. Each bit shuts the host out of one 32-byte quarter of bank 0. A host write can set lock bits but never clear them. Only the asynchronous power-on reset or the synchronous bus reset clears them. Neither reset touches the RAM contents. The bank 0 index is write-only at its own address, and its value is read back through a separate shadow register.

Host registers are selected by `{bank_i, off_i}`:

| Select | Register |
|---|---|
| 000 | bank 0 index (write-only) |
| 001 | bank 0 data |
| 010 | lock register |
| 011 | bank 0 index shadow (read-only) |
| 100 | bank 1 index |
| 101 | bank 1 data |

Top module: `cmos_lock_ram`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `rdata_o`, both index registers and the lock register all hold 0x00.
- R2: A read strobe (`rd_i`) updates `rdata_o` on the next rising clock edge. A data-register access reads or writes the byte of that bank selected by the bank's index.
- R3: Only index bits [6:0] select the RAM byte and the lock range. An index with bit 7 set reaches the same byte as the same index with bit 7 clear.
- R4: A read of select 000 returns 0x00. A read of select 011 returns the full 8-bit value last written to select 000.
- R5: The bank 1 index register (select 100) reads back all 8 bits that were written to it.
- R6: The lock register (select 010) reads its lock bits in bits [3:0] and zero in bits [7:4]. Selects 110 and 111 read 0x00.
- R7: A write to the lock register ORs data bits [3:0] into the lock bits. Writing zeros never clears a lock bit.
- R8: When lock bit k is set, bank 0 bytes with index[6:5] = k read 0xFF through the data register, and writes to them are discarded. Other quarters and bank 1 are unaffected.
- R9: `bus_rst_i` clears the lock bits and both index registers at the next clock edge. RAM contents are kept.
- R10: Bit 0 of bank 0 location 0x0B always reads 0, and writes to that bit are ignored. The same location in bank 1 stores all 8 bits.
- R11: Bank 0 and bank 1 hold separate storage. A write to one bank never changes the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| bus_rst_i | input | 1 | Synchronous bus reset, active high |
| bank_i | input | 1 | Bank select |
| off_i | input | 2 | Register offset within the bank |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |

## Verification
The assertions check on every cycle that lock bits never fall outside a bus reset, and that a bus reset empties the lock register. They also check that each read returns the required value for the reserved lock bits, the write-only index, the index shadow and any locked byte. The bench scenarios cover what depends on stored history. These are a full write/read sweep of both banks, aliasing through index bit 7, the discarding of writes to locked bytes, bank isolation, and RAM contents surviving a bus reset that clears the locks.

// File: rtl/cmos_ram_pkg.sv
package cmos_ram_pkg;
  // host register select = {bank_i, off_i}
  localparam logic [2:0] SEL_IDX0 = 3'b000;
  localparam logic [2:0] SEL_DAT0 = 3'b001;
  localparam logic [2:0] SEL_LOCK = 3'b010;
  localparam logic [2:0] SEL_SHDW = 3'b011;
  localparam logic [2:0] SEL_IDX1 = 3'b100;
  localparam logic [2:0] SEL_DAT1 = 3'b101;
  localparam int unsigned N_BANKS = 2;
endpackage

// File: rtl/cmos_idx_regs.sv
module cmos_idx_regs #(
  parameter int unsigned NB = 2,
  parameter int unsigned W  = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_rst_i,
  input  logic [NB-1:0]        we_i,
  input  logic [W-1:0]         wdata_i,
  output logic [NB-1:0][W-1:0] idx_o
);
  for (genvar b = 0; b < NB; b++) begin : g_idx
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        idx_o[b] <= '0;
      else if (bus_rst_i) idx_o[b] <= '0;
      else if (we_i[b])   idx_o[b] <= wdata_i;
    end
  end
endmodule

// File: rtl/cmos_lock_reg.sv
module cmos_lock_reg #(
  parameter int unsigned N_LOCK = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_rst_i,
  input  logic              set_i,
  input  logic [N_LOCK-1:0] set_bits_i,
  output logic [N_LOCK-1:0] lock_o
);
  // sticky: host can only OR bits in
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        lock_o <= '0;
    else if (bus_rst_i) lock_o <= '0;
    else if (set_i)     lock_o <= lock_o | set_bits_i;
  end
endmodule

// File: rtl/cmos_bank_ram.sv
module cmos_bank_ram #(
  parameter int unsigned    AW      = 7,
  parameter int unsigned    DW      = 8,
  parameter logic [AW-1:0]  RO_ADDR = '0,
  parameter logic [DW-1:0]  RO_MASK = '0
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] keep_zero;

  // read-only bits are held at zero
  assign keep_zero = (addr_i == RO_ADDR) ? RO_MASK : '0;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i & ~keep_zero;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/cmos_lock_ram.sv
module cmos_lock_ram
  import cmos_ram_pkg::*;
#(
  parameter int unsigned    IDX_W   = 7,
  parameter int unsigned    DATA_W  = 8,
  parameter int unsigned    N_LOCK  = 4,
  parameter logic [IDX_W-1:0]  RO_LOC  = 7'h0B,
  parameter logic [DATA_W-1:0] RO_BITS = 8'h01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_rst_i,
  input  logic              bank_i,
  input  logic [1:0]        off_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned NB     = N_BANKS;
  localparam int unsigned LSEL_W = $clog2(N_LOCK);

  logic [2:0]                   sel;
  logic [NB-1:0][DATA_W-1:0]    idx_q;
  logic [NB-1:0]                idx_we;
  logic [NB-1:0]                ram_we;
  logic [NB-1:0][DATA_W-1:0]    ram_rd;
  logic [N_LOCK-1:0]            lock_q;
  logic                         lock_set;
  logic                         locked0;
  logic [DATA_W-1:0]            rd_next;
  logic [DATA_W-1:0]            rdata_q;

  assign sel = {bank_i, off_i};

  assign idx_we[0] = wr_i && (sel == SEL_IDX0);
  assign idx_we[1] = wr_i && (sel == SEL_IDX1);
  assign lock_set  = wr_i && (sel == SEL_LOCK);

  // lock decode uses the same masked index as the RAM
  assign locked0 = lock_q[idx_q[0][IDX_W-1 -: LSEL_W]];

  assign ram_we[0] = wr_i && !bus_rst_i && (sel == SEL_DAT0) && !locked0;
  assign ram_we[1] = wr_i && !bus_rst_i && (sel == SEL_DAT1);

  cmos_idx_regs #(.NB(NB), .W(DATA_W)) u_idx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bus_rst_i (bus_rst_i),
    .we_i      (idx_we),
    .wdata_i   (wdata_i),
    .idx_o     (idx_q)
  );

  cmos_lock_reg #(.N_LOCK(N_LOCK)) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_rst_i  (bus_rst_i),
    .set_i      (lock_set),
    .set_bits_i (wdata_i[N_LOCK-1:0]),
    .lock_o     (lock_q)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    cmos_bank_ram #(
      .AW      (IDX_W),
      .DW      (DATA_W),
      .RO_ADDR (RO_LOC),
      .RO_MASK ((b == 0) ? RO_BITS : DATA_W'(0))
    ) u_ram (
      .clk_i   (clk_i),
      .we_i    (ram_we[b]),
      .addr_i  (idx_q[b][IDX_W-1:0]),
      .wdata_i (wdata_i),
      .rdata_o (ram_rd[b])
    );
  end

  always_comb begin
    unique case (sel)
      SEL_DAT0: rd_next = locked0 ? '1 : ram_rd[0];
      SEL_LOCK: rd_next = DATA_W'(lock_q);
      SEL_SHDW: rd_next = idx_q[0];
      SEL_IDX1: rd_next = idx_q[1];
      SEL_DAT1: rd_next = ram_rd[1];
      default:  rd_next = '0; // write-only index and unused selects
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_next;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/cmos_lock_ram_chk.sv
module cmos_lock_ram_chk #(
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned N_LOCK = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_rst_i,
  input logic              bank_i,
  input logic [1:0]        off_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [N_LOCK-1:0] lock_i,
  input logic [DATA_W-1:0] idx0_i
);
  localparam int unsigned LSEL_W = $clog2(N_LOCK);

  // R7: lock bits only fall on a bus reset
  a_r7_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rst_i |=> ((lock_i & $past(lock_i)) == $past(lock_i)));

  // R9: bus reset empties the lock register
  a_r9_bus_rst_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_i |=> (lock_i == '0));

  // R6: reserved lock bits read zero
  a_r6_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && {bank_i, off_i} == 3'b010) |=> (rdata_o[DATA_W-1:N_LOCK] == '0));

  // R4: write-only index reads zero
  a_r4_idx0_hidden: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && {bank_i, off_i} == 3'b000) |=> (rdata_o == '0));

  // R4: shadow returns the bank 0 index
  a_r4_shadow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && {bank_i, off_i} == 3'b011) |=> (rdata_o == $past(idx0_i)));

  // R8: locked bytes read all ones
  a_r8_locked_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && {bank_i, off_i} == 3'b001 && lock_i[idx0_i[IDX_W-1 -: LSEL_W]])
    |=> (rdata_o == '1));
endmodule

bind cmos_lock_ram cmos_lock_ram_chk #(
  .IDX_W(IDX_W), .DATA_W(DATA_W), .N_LOCK(N_LOCK)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bus_rst_i (bus_rst_i),
  .bank_i    (bank_i),
  .off_i     (off_i),
  .rd_i      (rd_i),
  .rdata_o   (rdata_o),
  .lock_i    (lock_q),
  .idx0_i    (idx_q[0])
);

// File: tb/cmos_lock_ram_test.sv
`timescale 1ns/1ps
module cmos_lock_ram_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bus_rst_i = 1'b0;
  logic       bank_i = 1'b0;
  logic [1:0] off_i = 2'd0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [2][128];

  always #2.5 clk = ~clk;

  cmos_lock_ram uut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_rst_i(bus_rst_i), .bank_i(bank_i),
    .off_i(off_i), .wr_i(wr_i), .rd_i(rd_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  function automatic logic [7:0] pat(int b, int a);
    return 8'((a * 7 + b * 53 + 1) & 255);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(logic [2:0] s, logic [7:0] d);
    @(negedge clk);
    {bank_i, off_i} = s; wdata_i = d; wr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic reg_rd(logic [2:0] s, output logic [7:0] d);
    @(negedge clk);
    {bank_i, off_i} = s; rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic put(int b, logic [7:0] idx, logic [7:0] d);
    reg_wr({b[0], 2'd0}, idx);
    reg_wr({b[0], 2'd1}, d);
  endtask

  task automatic get(int b, logic [7:0] idx, output logic [7:0] d);
    reg_wr({b[0], 2'd0}, idx);
    reg_rd({b[0], 2'd1}, d);
  endtask

  task automatic pulse_bus_rst();
    @(negedge clk); bus_rst_i = 1'b1;
    @(negedge clk); bus_rst_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    chk("R1 rdata in reset", rdata_o, 8'h00);
    rst_ni = 1'b1;
    reg_rd(3'b011, d); chk("R1 idx0 shadow", d, 8'h00);
    reg_rd(3'b100, d); chk("R1 idx1", d, 8'h00);
    reg_rd(3'b010, d); chk("R1 lock", d, 8'h00);

    // R2 R10 R11: full sweep of both banks
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 128; a++) begin
        put(b, 8'(a), pat(b, a));
        model[b][a] = (b == 0 && a == 11) ? (pat(b, a) & 8'hFE) : pat(b, a);
      end
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 128; a++) begin
        get(b, 8'(a), d);
        chk((a == 11) ? "R10 ro bit" : (b == 0 ? "R2 bank0" : "R11 bank1"), d, model[b][a]);
      end
    put(0, 8'h0B, 8'hFF); model[0][11] = 8'hFE;
    get(0, 8'h0B, d); chk("R10 ro bit forced", d, 8'hFE);
    get(1, 8'h0B, d); chk("R11 bank1 untouched", d, model[1][11]);

    // R3: index bit 7 aliases
    for (int b = 0; b < 2; b++)
      for (int a = 3; a < 128; a += 13) begin
        put(b, 8'(a) | 8'h80, 8'(a ^ 8'h5A ^ b));
        model[b][a] = (b == 0 && a == 11) ? 8'((a ^ 8'h5A ^ b) & 8'hFE) : 8'(a ^ 8'h5A ^ b);
        get(b, 8'(a), d); chk("R3 alias", d, model[b][a]);
      end

    // R4 R5 R6
    reg_wr(3'b000, 8'hA5);
    reg_rd(3'b000, d); chk("R4 idx0 write-only", d, 8'h00);
    reg_rd(3'b011, d); chk("R4 shadow", d, 8'hA5);
    reg_wr(3'b100, 8'hC3);
    reg_rd(3'b100, d); chk("R5 idx1", d, 8'hC3);
    reg_rd(3'b110, d); chk("R6 unused 6", d, 8'h00);
    reg_rd(3'b111, d); chk("R6 unused 7", d, 8'h00);

    // R6 R7 R8 R9: one lock bit at a time
    for (int k = 0; k < 4; k++) begin
      pulse_bus_rst();
      reg_wr(3'b010, 8'hF0 | 8'(1 << k));
      reg_rd(3'b010, d); chk("R6 lock map", d, 8'(1 << k));
      reg_wr(3'b010, 8'h00);
      reg_rd(3'b010, d); chk("R7 no clear", d, 8'(1 << k));
      for (int r = 0; r < 4; r++) begin
        int a;
        a = r * 32 + 5 + k;
        put(0, 8'(a), ~model[0][a]);
        if (r != k) model[0][a] = ~model[0][a];
        get(0, 8'(a), d); chk("R8 bank0 range", d, (r == k) ? 8'hFF : model[0][a]);
        get(1, 8'(a), d); chk("R8 bank1 free", d, model[1][a]);
        if (r == k) begin
          get(0, 8'(a) | 8'h80, d); chk("R3 lock alias", d, 8'hFF);
        end
      end
      pulse_bus_rst();
      reg_rd(3'b010, d); chk("R9 lock cleared", d, 8'h00);
      reg_rd(3'b011, d); chk("R9 idx0 cleared", d, 8'h00);
      reg_rd(3'b100, d); chk("R9 idx1 cleared", d, 8'h00);
      get(0, 8'(k * 33 + 5), d); chk("R9 data kept", d, model[0][k * 33 + 5]);
    end

    reg_wr(3'b010, 8'h0F);
    reg_rd(3'b010, d); chk("R7 all set", d, 8'h0F);
    get(0, 8'h7F, d); chk("R8 top locked", d, 8'hFF);
    pulse_bus_rst();
    get(0, 8'h7F, d); chk("R9 top kept", d, model[0][127]);

    $display("  Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end
endmodule